// File: doc/BRIEF.md
# Keyed Configuration Port with Logical-Device Pages

This block is a byte-wide configuration port that occupies two consecutive I/O addresses. The lower address holds a pointer (the index). The upper address moves a byte to or from the register the pointer names. The port is shut after reset. Host software opens it by writing the opening key to the index address twice in a row. While open, it can read fixed identification bytes, pick a logical device through a selector register, and reach that device's page of registers. Writing the closing key to the index address shuts the port again.

Every data access whose index lies in the page range is passed to a child block. The child sees the register offset, a one-cycle write or read strobe, the write byte and the selected device number. For devices below a parameterised count, the port keeps three page registers itself: a device enable bit and a 16-bit base address. It presents them as flat output vectors.

Top module: `cfg_port_bank`

## Requirements
- R1: Only two addresses respond: `BASE` is the index port and `BASE+1` the data port. A data access reaches the register the index currently holds. Writes and reads at any other address change nothing, and a read there leaves `io_rdata` unchanged.
- R2: The port opens after two consecutive index-port writes of 0x87 while shut. Key writes made while shut are never stored into the index, which resets to 0x00.
- R3: While shut, any index-port write other than 0x87 cancels a pending first key, so 0x87, 0x11, 0x87 leaves the port shut.
- R4: While open, an index-port write of 0xAA shuts the port and is not stored. While shut, data writes change no register and raise no child strobe, and reads at either port return 0x00.
- R5: A read (`io_rd` high with `io_wr` low) at either port loads `io_rdata` at the next clock edge. `io_rdata` holds its value in every other cycle. When `io_rd` and `io_wr` are high together, the cycle is treated as a write.
- R6: Index 0x07 is the read/write logical-device selector. Its value appears on `dev_sel`.
- R7: Indices 0x20 and 0x21 read the high and low bytes of `DEV_ID`, and 0x22 reads `DEV_REV`. Indices 0x23 and 0x24 read the vendor code 0x1934, high byte (0x19) at 0x23. Writes to these indices are ignored.
- R8: For a selected device below `NUM_LD`, the port keeps its own page registers. Index 0x30 bit 0 is the device enable; the other bits read 0. Index 0x60 holds the base high byte and 0x61 the low byte. Each device has separate storage. The enable appears at `ld_enable[d]` and the base at `ld_base[16*d +: 16]`.
- R9: Unimplemented indices below 0x30 read 0x00.
- R10: A data access while open with index 0x30 or above drives `dev_wr` or `dev_rd` high for exactly that cycle, with `dev_addr` equal to the index. A read returns `dev_rdata`, except for the page registers of R8, which return their local value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| io_addr | input | ADDR_W | I/O address |
| io_wr | input | 1 | I/O write strobe |
| io_rd | input | 1 | I/O read strobe |
| io_wdata | input | 8 | I/O write byte |
| io_rdata | output | 8 | Registered read byte |
| dev_sel | output | 8 | Selected logical device |
| dev_addr | output | 8 | Page register offset for the child |
| dev_wr | output | 1 | Child write strobe |
| dev_rd | output | 1 | Child read strobe |
| dev_wdata | output | 8 | Child write byte |
| dev_rdata | input | 8 | Child read byte |
| ld_enable | output | NUM_LD | Enable bit per logical device |
| ld_base | output | 16*NUM_LD | Base address per logical device |

## Verification
Some behaviours are checked by assertions on every cycle:
- child strobes stay silent while the port is shut, and the two strobes never rise together;
- the port opens only from the armed state, and a closing key shuts it on the next edge;
- the index, the selector, the page registers and `io_rdata` hold when nothing addresses them.

Other behaviours can only be shown by the bench's scenarios:
- the exact key orderings, including a cancelled key pair;
- the byte order of the identification registers;
- that page storage is kept apart per device;
- the choice between local and child read data for devices inside and outside `NUM_LD`.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;
  localparam logic [7:0] KEY_OPEN   = 8'h87;
  localparam logic [7:0] KEY_CLOSE  = 8'hAA;
  localparam logic [7:0] IX_LDSEL   = 8'h07;
  localparam logic [7:0] IX_DEV_HI  = 8'h20;
  localparam logic [7:0] IX_DEV_LO  = 8'h21;
  localparam logic [7:0] IX_REV     = 8'h22;
  localparam logic [7:0] IX_VEN_HI  = 8'h23;
  localparam logic [7:0] IX_VEN_LO  = 8'h24;
  localparam logic [7:0] IX_PAGE    = 8'h30;
  localparam logic [7:0] IX_LD_EN   = 8'h30;
  localparam logic [7:0] IX_BASE_HI = 8'h60;
  localparam logic [7:0] IX_BASE_LO = 8'h61;
  localparam logic [15:0] VENDOR_CODE = 16'h1934;

  // Index values at or above the page start go to the logical device.
  function automatic logic in_page(input logic [7:0] ix);
    return ix >= IX_PAGE;
  endfunction

  // Page registers the port keeps itself.
  function automatic logic local_page_reg(input logic [7:0] ix);
    return (ix == IX_LD_EN) || (ix == IX_BASE_HI) || (ix == IX_BASE_LO);
  endfunction

  // Byte read from the global (below page) register space.
  function automatic logic [7:0] global_byte(input logic [7:0] ix,
                                             input logic [7:0] ldn,
                                             input logic [15:0] dev_id,
                                             input logic [7:0] dev_rev);
    case (ix)
      IX_LDSEL:  return ldn;
      IX_DEV_HI: return dev_id[15:8];
      IX_DEV_LO: return dev_id[7:0];
      IX_REV:    return dev_rev;
      IX_VEN_HI: return VENDOR_CODE[15:8];
      IX_VEN_LO: return VENDOR_CODE[7:0];
      default:   return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/cfg_unlock_seq.sv
module cfg_unlock_seq
  import cfg_port_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       idx_wr,
  input  logic [7:0] wdata,
  output logic       open_o,
  output logic       absorb_o,
  output logic       unlock_ev,
  output logic       lock_ev
);
  logic armed_q;
  logic open_q;

  always_comb begin
    unlock_ev = idx_wr && !open_q && armed_q && (wdata == KEY_OPEN);
    lock_ev   = idx_wr && open_q && (wdata == KEY_CLOSE);
    // While shut nothing reaches the index; the closing key is consumed too.
    absorb_o  = idx_wr && (!open_q || lock_ev);
    open_o    = open_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q  <= 1'b0;
      armed_q <= 1'b0;
    end else if (unlock_ev) begin
      open_q  <= 1'b1;
      armed_q <= 1'b0;
    end else if (lock_ev) begin
      open_q  <= 1'b0;
      armed_q <= 1'b0;
    end else if (idx_wr && !open_q) begin
      armed_q <= (wdata == KEY_OPEN);
    end
  end

  AST_OPEN_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(open_q) |-> $past(armed_q)); // R2
  AST_ARM_ONLY_SHUT: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q |-> !open_q); // R3
  AST_CLOSE_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    lock_ev |=> !open_q); // R4
endmodule

// File: rtl/cfg_global_id.sv
module cfg_global_id
  import cfg_port_pkg::*;
#(
  parameter logic [15:0] DEV_ID  = 16'hA5C3,
  parameter logic [7:0]  DEV_REV = 8'h11
) (
  input  logic [7:0] ix,
  input  logic [7:0] ldn,
  output logic [7:0] rd_byte
);
  always_comb rd_byte = global_byte(ix, ldn, DEV_ID, DEV_REV);
endmodule

// File: rtl/cfg_ld_page.sv
module cfg_ld_page
  import cfg_port_pkg::*;
#(
  parameter int NUM_LD = 8,
  localparam int SEL_W = (NUM_LD > 1) ? $clog2(NUM_LD) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr,
  input  logic [7:0]           ix,
  input  logic [7:0]           ldn,
  input  logic [7:0]           wdata,
  output logic [NUM_LD-1:0]    en_vec,
  output logic [16*NUM_LD-1:0] base_flat,
  output logic                 hit,
  output logic [7:0]           rd_byte
);
  logic in_range;
  logic [SEL_W-1:0] sel;

  always_comb begin
    in_range = int'(ldn) < NUM_LD;
    sel      = ldn[SEL_W-1:0];
    hit      = in_range && local_page_reg(ix);
  end

  for (genvar g = 0; g < NUM_LD; g++) begin : g_ld
    logic        en_q;
    logic [15:0] base_q;
    logic        mine;
    always_comb mine = wr && in_range && (int'(ldn) == g);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        en_q   <= 1'b0;
        base_q <= 16'h0000;
      end else if (mine) begin
        if (ix == IX_LD_EN)   en_q         <= wdata[0];
        if (ix == IX_BASE_HI) base_q[15:8] <= wdata;
        if (ix == IX_BASE_LO) base_q[7:0]  <= wdata;
      end
    end
    assign en_vec[g]            = en_q;
    assign base_flat[16*g +: 16] = base_q;
  end

  always_comb begin
    rd_byte = 8'h00;
    if (hit) begin
      case (ix)
        IX_LD_EN:   rd_byte = {7'b0, en_vec[sel]};
        IX_BASE_HI: rd_byte = base_flat[16*sel + 8 +: 8];
        default:    rd_byte = base_flat[16*sel +: 8];
      endcase
    end
  end

  AST_PAGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> ($stable(en_vec) && $stable(base_flat))); // R8
endmodule

// File: rtl/cfg_port_bank.sv
module cfg_port_bank
  import cfg_port_pkg::*;
#(
  parameter int              ADDR_W  = 16,
  parameter logic [ADDR_W-1:0] BASE  = 16'h002E,
  parameter int              NUM_LD  = 8,
  parameter logic [15:0]     DEV_ID  = 16'hA5C3,
  parameter logic [7:0]      DEV_REV = 8'h11
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    io_addr,
  input  logic                 io_wr,
  input  logic                 io_rd,
  input  logic [7:0]           io_wdata,
  output logic [7:0]           io_rdata,
  output logic [7:0]           dev_sel,
  output logic [7:0]           dev_addr,
  output logic                 dev_wr,
  output logic                 dev_rd,
  output logic [7:0]           dev_wdata,
  input  logic [7:0]           dev_rdata,
  output logic [NUM_LD-1:0]    ld_enable,
  output logic [16*NUM_LD-1:0] ld_base
);
  localparam logic [ADDR_W-1:0] DATA_ADDR = BASE + ADDR_W'(1);

  // Named events for the assertions.
  logic at_idx, at_dat, rd_only;
  logic idx_wr, idx_rd, dat_wr, dat_rd;
  logic open, absorb, unlock_ev, lock_ev;
  logic page_sel, page_hit;
  logic [7:0] index_q, ldn_q, rdata_q;
  logic [7:0] page_byte, glob_byte, rd_next;

  always_comb begin
    at_idx  = io_addr == BASE;
    at_dat  = io_addr == DATA_ADDR;
    rd_only = io_rd && !io_wr;
    idx_wr  = io_wr && at_idx;
    idx_rd  = rd_only && at_idx;
    dat_wr  = io_wr && at_dat && open;
    dat_rd  = rd_only && at_dat && open;
    page_sel = in_page(index_q);
  end

  cfg_unlock_seq u_unlock (
    .clk       (clk),
    .rst_n     (rst_n),
    .idx_wr    (idx_wr),
    .wdata     (io_wdata),
    .open_o    (open),
    .absorb_o  (absorb),
    .unlock_ev (unlock_ev),
    .lock_ev   (lock_ev)
  );

  cfg_global_id #(.DEV_ID(DEV_ID), .DEV_REV(DEV_REV)) u_gid (
    .ix      (index_q),
    .ldn     (ldn_q),
    .rd_byte (glob_byte)
  );

  cfg_ld_page #(.NUM_LD(NUM_LD)) u_page (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr        (dat_wr && page_sel),
    .ix        (index_q),
    .ldn       (ldn_q),
    .wdata     (io_wdata),
    .en_vec    (ld_enable),
    .base_flat (ld_base),
    .hit       (page_hit),
    .rd_byte   (page_byte)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      index_q <= 8'h00;
      ldn_q   <= 8'h00;
    end else begin
      if (idx_wr && !absorb)                 index_q <= io_wdata;
      if (dat_wr && index_q == IX_LDSEL)     ldn_q   <= io_wdata;
    end
  end

  always_comb begin
    rd_next = 8'h00;
    if (open) begin
      if (at_idx)        rd_next = index_q;
      else if (!page_sel) rd_next = glob_byte;
      else if (page_hit)  rd_next = page_byte;
      else                rd_next = dev_rdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      rdata_q <= 8'h00;
    else if (rd_only && (at_idx || at_dat)) rdata_q <= rd_next;
  end

  always_comb begin
    io_rdata  = rdata_q;
    dev_sel   = ldn_q;
    dev_addr  = index_q;
    dev_wdata = io_wdata;
    dev_wr    = dat_wr && page_sel;
    dev_rd    = dat_rd && page_sel;
  end

  AST_SHUT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    !open |-> (!dev_wr && !dev_rd)); // R4
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({dev_wr, dev_rd})); // R10
  AST_SEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(io_wr && at_dat) |=> $stable(dev_sel)); // R6
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !io_rd |=> $stable(io_rdata)); // R5
  AST_KEY_NOT_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_wr && absorb) |=> $stable(dev_addr)); // R2
  AST_OPEN_EVENTS: assert property (@(posedge clk) disable iff (!rst_n)
    unlock_ev |=> open); // R2
endmodule

// File: tb/test_cfg_port_bank.sv
module test_cfg_port_bank;
  localparam time CLK_PERIOD = 10;
  localparam logic [15:0] BASE = 16'h002E;
  localparam int NUM_LD = 8;

  logic clk = 0, rst_n = 0;
  logic [15:0] io_addr = '0;
  logic io_wr = 0, io_rd = 0, track = 0;
  logic [7:0] io_wdata = '0, io_rdata;
  logic [7:0] dev_sel, dev_addr, dev_wdata, dev_rdata;
  logic dev_wr, dev_rd;
  logic [NUM_LD-1:0] ld_enable;
  logic [16*NUM_LD-1:0] ld_base;
  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  logic [7:0] exp_q[$];
  string tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  // Child model: read byte derived from offset and device number.
  assign dev_rdata = dev_addr ^ dev_sel ^ 8'h5A;

  cfg_port_bank #(.BASE(BASE), .NUM_LD(NUM_LD)) i_cfg_port_bank (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .dev_sel(dev_sel),
    .dev_addr(dev_addr), .dev_wr(dev_wr), .dev_rd(dev_rd),
    .dev_wdata(dev_wdata), .dev_rdata(dev_rdata), .ld_enable(ld_enable),
    .ld_base(ld_base)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Monitor: compares registered read data against the scoreboard.
  always @(posedge clk) begin
    if (track) begin
      #1;
      if (exp_q.size() == 0) chk(1, 0, "scoreboard underflow");
      else chk(io_rdata, exp_q.pop_front(), tag_q.pop_front());
    end
  end

  task automatic wr(input logic [15:0] a, input logic [7:0] d,
                    input logic exp_fwd, input string tag);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1;
    #1 chk(dev_wr, exp_fwd, tag);
    @(negedge clk);
    io_wr = 0;
  endtask

  task automatic rd(input logic [15:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    io_addr = a; io_rd = 1; track = 1;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    io_rd = 0; track = 0;
  endtask

  task automatic setreg(input logic [7:0] ix, input logic [7:0] v, input logic fwd, input string tag);
    wr(BASE, ix, 0, tag);
    wr(BASE + 1, v, fwd, tag);
  endtask

  task automatic getreg(input logic [7:0] ix, input logic [7:0] exp, input string tag);
    wr(BASE, ix, 0, tag);
    rd(BASE + 1, exp, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk(io_rdata, 8'h00, "R5 reset rdata");
    chk(ld_enable, '0, "R8 reset enables");
    // Shut: reads return zero, writes do nothing.
    getreg(8'h20, 8'h00, "R4 shut read");
    wr(BASE + 1, 8'h33, 0, "R4 shut write no strobe");
    // Broken key pair.
    wr(BASE, 8'h87, 0, "R3 key1");
    wr(BASE, 8'h11, 0, "R3 breaker");
    wr(BASE, 8'h87, 0, "R3 key1 again");
    wr(BASE, 8'h20, 0, "R3 clears");
    rd(BASE, 8'h00, "R3 still shut");
    // Proper open.
    wr(BASE, 8'h87, 0, "R2 key1");
    wr(BASE, 8'h87, 0, "R2 key2");
    rd(BASE, 8'h00, "R2 keys not stored in index");
    getreg(8'h20, 8'hA5, "R7 dev id hi");
    getreg(8'h21, 8'hC3, "R7 dev id lo");
    getreg(8'h22, 8'h11, "R7 revision");
    getreg(8'h23, 8'h19, "R7 vendor hi");
    getreg(8'h24, 8'h34, "R7 vendor lo");
    setreg(8'h23, 8'h55, 0, "R7 write ignored");
    getreg(8'h23, 8'h19, "R7 vendor after write");
    getreg(8'h25, 8'h00, "R9 unimplemented 25");
    getreg(8'h10, 8'h00, "R9 unimplemented 10");
    // Selector and page of device 7.
    setreg(8'h07, 8'h07, 0, "R6 select 7");
    getreg(8'h07, 8'h07, "R6 readback");
    chk(dev_sel, 8'h07, "R6 dev_sel");
    setreg(8'h30, 8'hFF, 1, "R10 fwd enable write");
    chk(dev_addr, 8'h30, "R10 dev_addr");
    getreg(8'h30, 8'h01, "R8 enable bit only");
    chk(ld_enable, 8'h80, "R8 enable vector");
    setreg(8'h60, 8'h0A, 1, "R8 base hi");
    setreg(8'h61, 8'h20, 1, "R8 base lo");
    chk(ld_base[16*7 +: 16], 16'h0A20, "R8 base out");
    getreg(8'h60, 8'h0A, "R8 base hi read");
    // Device 2 has its own storage.
    setreg(8'h07, 8'h02, 0, "R6 select 2");
    getreg(8'h30, 8'h00, "R8 separate enable");
    setreg(8'h60, 8'h03, 1, "R8 dev2 base hi");
    chk(ld_base[16*2 +: 16], 16'h0300, "R8 dev2 base");
    chk(ld_base[16*7 +: 16], 16'h0A20, "R8 dev7 untouched");
    getreg(8'h45, 8'h1D, "R10 child read");
    // Device outside local range goes to the child.
    setreg(8'h07, 8'h09, 0, "R6 select 9");
    getreg(8'h30, 8'h63, "R10 child for far device");
    // Other addresses do nothing.
    wr(BASE + 2, 8'hAA, 0, "R1 foreign write");
    rd(BASE, 8'h30, "R1 still open");
    @(negedge clk); io_addr = BASE + 3; io_rd = 1;
    @(negedge clk); io_rd = 0;
    chk(io_rdata, 8'h30, "R1 foreign read keeps rdata");
    repeat (3) @(negedge clk);
    chk(io_rdata, 8'h30, "R5 rdata holds");
    // Close, then writes are ignored.
    setreg(8'h07, 8'h02, 0, "R6 select 2 again");
    wr(BASE, 8'hAA, 0, "R4 close");
    rd(BASE + 1, 8'h00, "R4 shut data read");
    wr(BASE + 1, 8'h05, 0, "R4 shut data write");
    wr(BASE, 8'h87, 0, "R2 reopen 1");
    wr(BASE, 8'h87, 0, "R2 reopen 2");
    rd(BASE, 8'h07, "R4 close key not stored");
    rd(BASE + 1, 8'h02, "R4 selector unchanged");
    chk(dev_sel, 8'h02, "R6 dev_sel after shut write");
    repeat (3) @(negedge clk);
    chk(exp_q.size(), 0, "scoreboard drained");
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule